// File: doc/BRIEF.md
# Port-mapped RAM disk controller

This block lets a host processor use up to eight banks of on-chip RAM as solid-state disks through a window of two byte-wide I/O ports. The host first loads a 22-bit transfer pointer. It does this by writing bytes to the pointer port, most significant byte first. It then moves data through the data port one byte at a time. After every data access the pointer steps forward by one. When the step carries out of the byte offset, the pointer moves on into the next bank.

The three top bits of the pointer pick the bank. Each bank has a configuration input that enables it and another that write-protects it. A protected bank ignores writes. A bank that is not enabled reads as 0xFF and drops writes. In both cases the pointer still advances. Each bank is built with a parameterised number of offset bits. Pointer offset bits above that width are ignored when the bank is indexed.

A small read-back state machine chooses what the output byte shows. Its states are:
- `ST_IDLE`: entered at reset; the output shows 0xFF.
- `ST_SHOW_DATA`: the last read was a data read from an enabled bank.
- `ST_SHOW_FF`: the last read was a pointer-port read or a read from a disabled bank.

Its transitions are:
- `data_read_enabled`: any state to `ST_SHOW_DATA`.
- `data_read_disabled`: any state to `ST_SHOW_FF`.
- `ptr_read`: any state to `ST_SHOW_FF`.
- `hold`: no read, so the state is kept and the output byte stays as it was.

Top module: `ramdisk_ctrl`

## Requirements
- R1: A write strobe with `io_sel` high and `io_a0`=1 (pointer port) sets the pointer to ((pointer << 8) | din) truncated to 22 bits, so three writes, high byte first, load a full pointer.
- R2: A read strobe with `io_a0`=1 makes `dout` 0xFF on the following cycle and leaves the pointer unchanged.
- R3: Pointer bits 21:19 select the bank. Only the low `MEM_OFS_W` bits of pointer bits 18:0 index the bank, so offsets that differ only above those bits reach the same byte.
- R4: A read strobe with `io_a0`=0 (data port) to an enabled bank presents the stored byte on `dout` on the cycle after the strobe. `dout` then holds that byte until the next read.
- R5: A data-port read from a bank whose `unit_en` bit is 0 returns 0xFF.
- R6: Every data-port read or write adds one to the pointer, modulo 2^22. A carry out of bit 18 moves into the next bank, and 0x3FFFFF wraps to 0.
- R7: A data-port write to an enabled bank whose `unit_wlock` bit is 1 leaves its storage unchanged, and the pointer still advances.
- R8: A data-port write to a disabled bank is dropped, and the pointer still advances.
- R9: Reset (`rst_n` low) clears the pointer to 0 and sets `dout` to 0xFF. Bank contents are kept.
- R10: Strobes while `io_sel` is low change neither the pointer nor any storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 1 | The access falls in the two-port window |
| io_a0 | input | 1 | Port select: 0 data, 1 pointer |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| din | input | 8 | Write byte |
| dout | output | 8 | Read byte, valid on the cycle after a read strobe |
| unit_en | input | 8 | Per-bank enable |
| unit_wlock | input | 8 | Per-bank write protect |

## Verification
A wrong pointer shows up on the very next data read as a byte from the wrong place. It also shows up a few accesses later, when a stream runs past a bank boundary or the top of the pointer space. A wrong bank decode or protect check only shows when that location is read back, which may be many cycles after the faulty write. For this reason every write in the bench is later read back and compared against an independent model. A read-back state machine stuck in the wrong state shows on `dout` one cycle after the read strobe that should have moved it.

// File: rtl/ramdisk_pkg.sv
package ramdisk_pkg;
    localparam int XA_W      = 22;
    localparam int UNIT_LSB  = 19;
    localparam int UNIT_W    = XA_W - UNIT_LSB;
    localparam int NUM_UNITS = 1 << UNIT_W;
    localparam int BYTE_W    = 8;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_SHOW_DATA = 2'd1,
        ST_SHOW_FF   = 2'd2
    } rd_state_e;
endpackage

// File: rtl/rd_xfer_addr.sv
module rd_xfer_addr #(
    parameter int ADDR_W = 22,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              inc,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= {addr[ADDR_W-BYTE_W-1:0], byte_in};
        end else if (inc) begin
            addr <= addr + 1'b1;
        end
    end

    assert_ptr_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr == {$past(addr[ADDR_W-BYTE_W-1:0]), $past(byte_in)});

    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> addr == ADDR_W'($past(addr) + 1'b1));

    assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(addr));
endmodule

// File: rtl/rd_unit_ram.sv
module rd_unit_ram #(
    parameter int OFS_W  = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [OFS_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] q
);
    localparam int DEPTH = 1 << OFS_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
        if (re) begin
            q <= mem[idx];
        end
    end
endmodule

// File: rtl/rd_read_fsm.sv
module rd_read_fsm
    import ramdisk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_rd,
    input  logic              addr_rd,
    input  logic              unit_ok,
    input  logic [BYTE_W-1:0] mem_byte,
    output logic [BYTE_W-1:0] dout
);
    rd_state_e st, st_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st;
        if (data_rd) begin
            st_nxt = unit_ok ? ST_SHOW_DATA : ST_SHOW_FF;
        end else if (addr_rd) begin
            st_nxt = ST_SHOW_FF;
        end
    end

    always_comb begin
        unique case (st)
            ST_IDLE:      dout = '1;
            ST_SHOW_DATA: dout = mem_byte;
            ST_SHOW_FF:   dout = '1;
            default:      dout = '1;
        endcase
    end
endmodule

// File: rtl/ramdisk_ctrl.sv
module ramdisk_ctrl
    import ramdisk_pkg::*;
#(
    parameter int MEM_OFS_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_sel,
    input  logic                 io_a0,
    input  logic                 rd_stb,
    input  logic                 wr_stb,
    input  logic [BYTE_W-1:0]    din,
    output logic [BYTE_W-1:0]    dout,
    input  logic [NUM_UNITS-1:0] unit_en,
    input  logic [NUM_UNITS-1:0] unit_wlock
);
    logic                 data_rd, data_wr, addr_rd, addr_wr, data_acc;
    logic [XA_W-1:0]      xa;
    logic [UNIT_W-1:0]    cur_unit, rd_unit_q;
    logic [MEM_OFS_W-1:0] cur_idx;
    logic [NUM_UNITS-1:0] we_vec, re_vec;
    logic [BYTE_W-1:0]    mem_q [NUM_UNITS];
    logic                 unit_ok;

    assign data_rd  = io_sel && rd_stb && !io_a0;
    assign data_wr  = io_sel && wr_stb && !io_a0;
    assign addr_rd  = io_sel && rd_stb &&  io_a0;
    assign addr_wr  = io_sel && wr_stb &&  io_a0;
    assign data_acc = data_rd || data_wr;

    rd_xfer_addr #(.ADDR_W(XA_W), .BYTE_W(BYTE_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (addr_wr),
        .inc     (data_acc),
        .byte_in (din),
        .addr    (xa)
    );

    assign cur_unit = xa[XA_W-1:UNIT_LSB];
    assign cur_idx  = xa[MEM_OFS_W-1:0];
    assign unit_ok  = unit_en[cur_unit];

    generate
        if (MEM_OFS_W < UNIT_LSB) begin : g_alias
            logic ofs_unused;
            assign ofs_unused = ^xa[UNIT_LSB-1:MEM_OFS_W];
        end
    endgenerate

    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            assign we_vec[u] = data_wr && (cur_unit == UNIT_W'(u))
                               && unit_en[u] && !unit_wlock[u];
            assign re_vec[u] = data_rd && (cur_unit == UNIT_W'(u));

            rd_unit_ram #(.OFS_W(MEM_OFS_W), .BYTE_W(BYTE_W)) u_ram (
                .clk   (clk),
                .we    (we_vec[u]),
                .re    (re_vec[u]),
                .idx   (cur_idx),
                .wdata (din),
                .q     (mem_q[u])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_unit_q <= '0;
        end else if (data_rd) begin
            rd_unit_q <= cur_unit;
        end
    end

    rd_read_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_rd  (data_rd),
        .addr_rd  (addr_rd),
        .unit_ok  (unit_ok),
        .mem_byte (mem_q[rd_unit_q]),
        .dout     (dout)
    );

    assert_ptr_read_ff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_rd |=> (dout == 8'hFF) && $stable(xa));

    assert_off_unit_ff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !unit_en[cur_unit]) |=> dout == 8'hFF);

    assert_single_bank_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec) && ((we_vec & unit_wlock) == '0));
endmodule

// File: tb/test_ramdisk_ctrl.sv
module test_ramdisk_ctrl;
    localparam int OFS_W = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_sel = 1'b0, io_a0 = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic [7:0] unit_en = 8'h7F;
    logic [7:0] unit_wlock = 8'h04;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]  mm [8][256];
    logic [21:0] m_addr = '0;
    logic [7:0]  exp_q [$];
    string       tag_q [$];
    logic        mon_arm = 1'b0;

    always #10 clk = ~clk;

    ramdisk_ctrl #(.MEM_OFS_W(OFS_W)) i_ramdisk_ctrl (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_a0(io_a0),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .din(din), .dout(dout),
        .unit_en(unit_en), .unit_wlock(unit_wlock)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic idle_bus();
        @(negedge clk);
        io_sel = 0; rd_stb = 0; wr_stb = 0;
    endtask

    task automatic wr_ptr(input logic [7:0] b, input logic sel = 1'b1);
        @(negedge clk);
        io_sel = sel; io_a0 = 1; wr_stb = 1; rd_stb = 0; din = b;
        if (sel) m_addr = {m_addr[13:0], b};
        idle_bus();
    endtask

    task automatic load_ptr(input logic [21:0] a);
        wr_ptr({2'b00, a[21:16]});
        wr_ptr(a[15:8]);
        wr_ptr(a[7:0]);
    endtask

    task automatic wr_data(input logic [7:0] b, input logic sel = 1'b1);
        @(negedge clk);
        io_sel = sel; io_a0 = 0; wr_stb = 1; rd_stb = 0; din = b;
        if (sel) begin
            if (unit_en[m_addr[21:19]] && !unit_wlock[m_addr[21:19]])
                mm[m_addr[21:19]][m_addr[7:0]] = b;
            m_addr = m_addr + 1'b1;
        end
        idle_bus();
    endtask

    task automatic rd_data(input string tag);
        @(negedge clk);
        exp_q.push_back(unit_en[m_addr[21:19]] ? mm[m_addr[21:19]][m_addr[7:0]] : 8'hFF);
        tag_q.push_back(tag);
        m_addr = m_addr + 1'b1;
        io_sel = 1; io_a0 = 0; rd_stb = 1; wr_stb = 0;
        idle_bus();
    endtask

    task automatic rd_ptr(input string tag);
        @(negedge clk);
        exp_q.push_back(8'hFF);
        tag_q.push_back(tag);
        io_sel = 1; io_a0 = 1; rd_stb = 1; wr_stb = 0;
        idle_bus();
    endtask

    // Monitor: arms on a selected read strobe, compares one cycle later.
    always @(posedge clk) mon_arm <= io_sel && rd_stb;

    always @(negedge clk) begin
        if (mon_arm) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL monitor unexpected read actual=%02h expected=none", dout);
            end else begin
                check(tag_q.pop_front(), dout, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R9 reset dout", dout, 8'hFF);

        // R9: pointer is 0 after reset
        wr_data(8'hA5);
        load_ptr(22'h0);
        rd_data("R9 reset pointer zero");

        // R1 R4 R6: load, stream write and read back; R2 pointer read
        load_ptr(22'h080042);
        wr_data(8'h11); wr_data(8'h22); wr_data(8'h33);
        load_ptr(22'h080042);
        rd_data("R4 read first byte");
        rd_ptr("R2 pointer read gives FF");
        rd_data("R2 pointer unchanged by port read");
        rd_data("R1 R6 stream third byte");

        // R6 bank boundary crossing
        load_ptr(22'h07FFFF);
        wr_data(8'hAA); wr_data(8'hBB);
        load_ptr(22'h07FFFF);
        rd_data("R6 last byte of bank 0");
        rd_data("R6 first byte of bank 1");

        // R5 R8 disabled bank 7, R6 wrap to 0
        load_ptr(22'h3FFFFF);
        rd_data("R5 disabled bank reads FF");
        rd_data("R6 wrap to pointer 0");
        load_ptr(22'h3FFFFF);
        wr_data(8'h77);
        rd_data("R8 dropped write still advances");

        // R7 locked bank 2
        unit_wlock = 8'h00;
        load_ptr(22'h100010);
        wr_data(8'h5C); wr_data(8'h6D);
        unit_wlock = 8'h04;
        load_ptr(22'h100010);
        wr_data(8'hC3);
        rd_data("R7 locked write advances pointer");
        load_ptr(22'h100010);
        rd_data("R7 locked storage unchanged");

        // R3 offset aliasing above MEM_OFS_W
        load_ptr(22'h180010);
        wr_data(8'h9E);
        load_ptr(22'h190010);
        rd_data("R3 upper offset bits ignored");

        // R10 deselected strobes
        load_ptr(22'h180010);
        wr_data(8'h55, 1'b0);
        wr_ptr(8'h3C, 1'b0);
        rd_data("R10 deselected strobes ignored");

        // R9 reset mid-run clears pointer, keeps storage
        load_ptr(22'h180010);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        m_addr = '0;
        @(negedge clk);
        check("R9 dout after second reset", dout, 8'hFF);
        rd_data("R9 second reset pointer zero");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL monitor pending reads actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule